// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date for a chip that receives a 32.768 kHz reference as a clock enable. It counts pulses of that enable into a one-second strobe. Each strobe advances a chain of packed-BCD fields: seconds, minutes, hours (24-hour form), a day-of-week count, day of month, month, and a two-digit year. A carry moves from one field to the next only when the lower field rolls over.

A host loads any single field through a small write port. The port takes a field selector and a BCD byte. A write also restarts the sub-second divider from zero, so the first strobe after a write comes one full second later. The leap rule treats every year divisible by four as a leap year. This is correct for the years 2000 through 2099, and no century logic is present. The current field values are always visible on the outputs, together with the one-cycle second strobe.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, weekday 0, date 01, month 01, year 00, and the strobe is low.
- R2: `tick_o` goes high for exactly one cycle after every REF_DIV sampled pulses of `ref_en`. The strobe is never high in two consecutive cycles.
- R3: Each strobe advances seconds by one in BCD. After 59, seconds return to 00 and carry into minutes.
- R4: Minutes count 00 to 59. Rolling over from 59 returns them to 00 and carries into hours.
- R5: Hours count 00 to 23. Rolling over from 23 returns them to 00 and produces a day carry.
- R6: On every day carry the weekday steps through 0 to 6 and returns from 6 to 0, whatever the date does.
- R7: Months 01, 03, 05, 07, 08, 10 and 12 end after date 31, and months 04, 06, 09 and 11 end after date 30. At the end of a month the date returns to 01 and the month increments.
- R8: February ends after date 29 when the BCD year's value is divisible by four (year 00 included), and after date 28 otherwise.
- R9: After month 12 the month returns to 01 and the year increments. The year wraps from 99 to 00.
- R10: A cycle with `wr_en` high loads `wr_data` into the field picked by `wr_sel`: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year. Selector 7 changes no field.
- R11: A write clears the divider and drops any advance in that cycle. The next strobe follows REF_DIV `ref_en` pulses counted from the cycle after the write.
- R12: No field changes in a cycle that has neither a write nor an advance from the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle pulse per reference period (32.768 kHz) |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector for the write |
| wr_data | input | 8 | Packed BCD value to load |
| tick_o | output | 1 | One-cycle pulse per second |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD, 24-hour |
| wday_o | output | 8 | Weekday 0 to 6 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |

## Verification
The assertions assume that every write carries a legal BCD value inside its field's range. For the date, the value must also not exceed the length of the current month. Under that assumption, each low nibble stays at 9 or below and the weekday stays at 6 or below. The bench writes only legal calendar values, and it sets the year and month before the date. It lets `ref_en` arrive in an irregular pseudo-random pattern, so the divider is exercised with gaps between pulses. The bench never drives a selector value with data that would be out of range.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int NFIELD = 7;
   localparam int FW     = 8;

   typedef enum logic [2:0] {
      F_SEC   = 3'd0,
      F_MIN   = 3'd1,
      F_HOUR  = 3'd2,
      F_WDAY  = 3'd3,
      F_DATE  = 3'd4,
      F_MONTH = 3'd5,
      F_YEAR  = 3'd6
   } field_e;

   function automatic logic [6:0] bcd2bin(input logic [7:0] b);
      return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
   endfunction

   // Year value mod 4 equals (2*tens + ones) mod 4
   function automatic logic is_leap(input logic [7:0] yr);
      logic [4:0] s;
      s = {1'b0, yr[7:4]} + {1'b0, yr[7:4]} + {1'b0, yr[3:0]};
      return (s[1:0] == 2'b00);
   endfunction

   function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] yr);
      case (mo)
         8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic logic [7:0] field_floor(input int i);
      return (i == int'(F_DATE) || i == int'(F_MONTH)) ? 8'h01 : 8'h00;
   endfunction

   function automatic logic [7:0] field_ceil(input int i);
      case (i)
         0, 1:    return 8'h59;
         2:       return 8'h23;
         3:       return 8'h06;
         5:       return 8'h12;
         default: return 8'h99;
      endcase
   endfunction

   // Index of the field whose rollover feeds field i; -1 means the second strobe
   function automatic int carry_src(input int i);
      case (i)
         0:       return -1;
         4:       return 2;
         5:       return 4;
         default: return i - 1;
      endcase
   endfunction

endpackage

// File: rtl/rtc_sec_divider.sv
module rtc_sec_divider #(
   parameter int REF_DIV = 32768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_en,
   input  logic hold,
   output logic tick
);
   localparam int CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(REF_DIV - 1);

   if (REF_DIV < 2) begin : g_bad_div
      $error("rtc_sec_divider: REF_DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (hold) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (ref_en) begin
         if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
         end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
         end
      end else begin
         tick <= 1'b0;
      end
   end

   p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   p_tick_from_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> $past(ref_en));
   p_hold_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> !tick);

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
   import rtc_cal_pkg::*;
#(
   parameter logic [FW-1:0] FLOOR = 8'h00
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [FW-1:0] ld_val,
   input  logic          inc,
   input  logic [FW-1:0] ceil_bcd,
   output logic [FW-1:0] val,
   output logic          wrap
);
   logic [FW-1:0] nxt;

   always_comb begin
      wrap = inc && (bcd2bin(val) >= bcd2bin(ceil_bcd));
      if (wrap)
         nxt = FLOOR;
      else if (val[3:0] >= 4'd9)
         nxt = {val[7:4] + 4'd1, 4'd0};
      else
         nxt = {val[7:4], val[3:0] + 4'd1};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         val <= FLOOR;
      else if (ld)
         val <= ld_val;
      else if (inc)
         val <= nxt;
   end

   // R12: a field moves only on a load or an increment
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld && !inc) |=> $stable(val));
   p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (val == $past(ld_val)));
   // Carries in R3, R4, R5, R6, R9 always land on the floor value
   p_wrap_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !ld) |=> (val == FLOOR));
   p_bcd_digit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      val[3:0] <= 4'd9);

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
   import rtc_cal_pkg::*;
#(
   parameter int REF_DIV = 32768
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_en,
   input  logic       wr_en,
   input  logic [2:0] wr_sel,
   input  logic [7:0] wr_data,
   output logic       tick_o,
   output logic [7:0] sec_o,
   output logic [7:0] min_o,
   output logic [7:0] hour_o,
   output logic [7:0] wday_o,
   output logic [7:0] date_o,
   output logic [7:0] month_o,
   output logic [7:0] year_o
);
   logic          tick;
   logic [FW-1:0] fv    [NFIELD];
   logic [FW-1:0] ceilv [NFIELD];
   logic          wrapv [NFIELD];
   logic          incv  [NFIELD];

   rtc_sec_divider #(.REF_DIV(REF_DIV)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_en (ref_en),
      .hold   (wr_en),
      .tick   (tick)
   );

   for (genvar g = 0; g < NFIELD; g++) begin : g_field
      localparam int SRC = carry_src(g);

      if (SRC < 0) begin : g_from_tick
         assign incv[g] = tick && !wr_en;
      end else begin : g_from_field
         assign incv[g] = wrapv[SRC];
      end

      if (g == int'(F_DATE)) begin : g_ceil_month
         assign ceilv[g] = month_last(fv[F_MONTH], fv[F_YEAR]);
      end else begin : g_ceil_fixed
         assign ceilv[g] = field_ceil(g);
      end

      rtc_bcd_field #(.FLOOR(field_floor(g))) u_fld (
         .clk      (clk),
         .rst_n    (rst_n),
         .ld       (wr_en && (wr_sel == 3'(g))),
         .ld_val   (wr_data),
         .inc      (incv[g]),
         .ceil_bcd (ceilv[g]),
         .val      (fv[g]),
         .wrap     (wrapv[g])
      );
   end

   assign tick_o  = tick;
   assign sec_o   = fv[F_SEC];
   assign min_o   = fv[F_MIN];
   assign hour_o  = fv[F_HOUR];
   assign wday_o  = fv[F_WDAY];
   assign date_o  = fv[F_DATE];
   assign month_o = fv[F_MONTH];
   assign year_o  = fv[F_YEAR];

   p_quiet_between_ticks_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !tick_o) |=> $stable({sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o}));
   p_bad_sel_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 3'd7) |=> $stable({sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o}));
   p_new_month_day_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (!$changed(month_o) || date_o == 8'h01));
   p_wday_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wday_o <= 8'h06);
   p_sec_moves_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && !wr_en) |=> $changed(sec_o));

endmodule

// File: tb/rtc_bcd_calendar_tb.sv
`timescale 1ns/1ps
module rtc_bcd_calendar_tb;
   localparam int DIV = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'h00;
   logic       tick_o;
   logic [7:0] sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   int m_f [7];
   int m_cnt  = 0;
   int m_tick = 0;
   int since  = 0;

   always #2.5 clk = ~clk;

   rtc_bcd_calendar #(.REF_DIV(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .tick_o(tick_o),
      .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
      .date_o(date_o), .month_o(month_o), .year_o(year_o)
   );

   function automatic int b2i(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic int days_in(input int mo, input int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_advance();
      m_f[0]++;
      if (m_f[0] == 60) begin
         m_f[0] = 0; m_f[1]++;
         if (m_f[1] == 60) begin
            m_f[1] = 0; m_f[2]++;
            if (m_f[2] == 24) begin
               m_f[2] = 0;
               m_f[3] = (m_f[3] + 1) % 7;
               m_f[4]++;
               if (m_f[4] > days_in(m_f[5], m_f[6])) begin
                  m_f[4] = 1; m_f[5]++;
                  if (m_f[5] > 12) begin
                     m_f[5] = 1;
                     m_f[6] = (m_f[6] + 1) % 100;
                  end
               end
            end
         end
      end
   endtask

   // Behavioural reference model
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_f[0] = 0; m_f[1] = 0; m_f[2] = 0; m_f[3] = 0;
         m_f[4] = 1; m_f[5] = 1; m_f[6] = 0;
         m_cnt = 0; m_tick = 0;
      end else if (wr_en) begin
         if (wr_sel < 3'd7) m_f[wr_sel] = b2i(wr_data);
         m_cnt = 0; m_tick = 0;
      end else begin
         if (m_tick != 0) model_advance();
         if (ref_en) begin
            if (m_cnt == DIV - 1) begin m_cnt = 0; m_tick = 1; end
            else begin m_cnt++; m_tick = 0; end
         end else begin
            m_tick = 0;
         end
      end
   end

   // Pulses of ref_en seen since the last write or strobe
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)      since <= 0;
      else if (wr_en)  since <= 0;
      else if (tick_o) since <= ref_en ? 1 : 0;
      else             since <= since + (ref_en ? 1 : 0);
   end

   always @(negedge clk) ref_en <= ($urandom % 3) != 0;

   // Compare against the model every cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2",  "tick",  int'(tick_o), m_tick);
         check("R12", "sec",   b2i(sec_o),   m_f[0]);
         check("R12", "min",   b2i(min_o),   m_f[1]);
         check("R12", "hour",  b2i(hour_o),  m_f[2]);
         check("R12", "wday",  b2i(wday_o),  m_f[3]);
         check("R12", "date",  b2i(date_o),  m_f[4]);
         check("R12", "month", b2i(month_o), m_f[5]);
         check("R12", "year",  b2i(year_o),  m_f[6]);
         if (tick_o) check("R11", "ref pulses per strobe", since, DIV);
      end
   end

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_all(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                          input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se,
                          input logic [7:0] wd);
      wr(3'd6, yr); wr(3'd5, mo); wr(3'd4, dt);
      wr(3'd2, hr); wr(3'd1, mi); wr(3'd0, se); wr(3'd3, wd);
   endtask

   task automatic wait_tick();
      @(negedge clk);
      while (!tick_o) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [55:0] snap;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "sec",   int'(sec_o),   8'h00);
      check("R1", "min",   int'(min_o),   8'h00);
      check("R1", "hour",  int'(hour_o),  8'h00);
      check("R1", "wday",  int'(wday_o),  8'h00);
      check("R1", "date",  int'(date_o),  8'h01);
      check("R1", "month", int'(month_o), 8'h01);
      check("R1", "year",  int'(year_o),  8'h00);
      check("R1", "tick",  int'(tick_o),  0);
      rst_n = 1'b1;

      // R3: plain second counting
      repeat (3) wait_tick();
      check("R3", "sec after 3", int'(sec_o), 8'h03);

      // R4: minute carry
      set_all(8'h21, 8'h06, 8'h15, 8'h12, 8'h34, 8'h58, 8'h02);
      repeat (2) wait_tick();
      check("R4", "min", int'(min_o), 8'h35);
      check("R3", "sec", int'(sec_o), 8'h00);
      check("R4", "hour kept", int'(hour_o), 8'h12);

      // R8: non-leap February, plus R5 and R6
      set_all(8'h03, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h06);
      wait_tick();
      check("R8", "date", int'(date_o), 8'h01);
      check("R8", "month", int'(month_o), 8'h03);
      check("R5", "hour", int'(hour_o), 8'h00);
      check("R4", "min", int'(min_o), 8'h00);
      check("R6", "wday wrap", int'(wday_o), 8'h00);

      // R8: leap February
      set_all(8'h04, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h02);
      wait_tick();
      check("R8", "date leap", int'(date_o), 8'h29);
      check("R8", "month leap", int'(month_o), 8'h02);
      check("R6", "wday", int'(wday_o), 8'h03);

      // R8: year 00 counts as leap and ends after 29
      set_all(8'h00, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59, 8'h04);
      wait_tick();
      check("R8", "date y00", int'(date_o), 8'h01);
      check("R8", "month y00", int'(month_o), 8'h03);

      // R7: 30-day and 31-day months
      set_all(8'h10, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59, 8'h01);
      wait_tick();
      check("R7", "date after Apr 30", int'(date_o), 8'h01);
      check("R7", "month after Apr", int'(month_o), 8'h05);
      set_all(8'h10, 8'h01, 8'h31, 8'h23, 8'h59, 8'h59, 8'h01);
      wait_tick();
      check("R7", "date after Jan 31", int'(date_o), 8'h01);
      check("R7", "month after Jan", int'(month_o), 8'h02);

      // R9: year end and year wrap
      set_all(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, 8'h05);
      wait_tick();
      check("R9", "month", int'(month_o), 8'h01);
      check("R9", "year wrap", int'(year_o), 8'h00);
      check("R9", "date", int'(date_o), 8'h01);

      // R10: selector 7 leaves every field alone; selector 2 loads hours
      @(negedge clk);
      snap = {sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o};
      wr(3'd7, 8'h42);
      check("R10", "sel 7 ignored",
            int'({sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o} == snap), 1);
      wr(3'd2, 8'h17);
      check("R10", "hour load", int'(hour_o), 8'h17);

      // R11: write restarts the second; per-strobe count checked every strobe
      repeat (4) begin
         wr(3'd0, 8'h10);
         wait_tick();
         check("R11", "sec one second after write", int'(sec_o), 8'h11);
      end

      repeat (70) wait_tick();
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule